// File: doc/BRIEF.md
# Store-and-Forward Packet Buffer with Error Discard

This block is a single-clock packet buffer that sits between a MAC and its client. Beats arrive on a 64-bit valid/ready stream that carries start-of-packet, end-of-packet, a count of unused bytes (empty) and an error flag. Each beat is stored together with all of its sideband bits. Beats leave on a second valid/ready stream with the same fields.

In store-and-forward mode, the write side holds two pointers. The first is a speculative write pointer that moves with every stored beat. The second is a committed pointer that moves only when an end-of-packet beat is stored. The read side sees only committed beats, so a frame appears on the output only after its last beat is in the buffer. With error discard enabled, a frame whose end beat carries the error flag is removed by moving the write pointer back to the committed pointer. A frame that runs out of space before its end beat is removed the same way. The input then stays ready and swallows the rest of that frame.

With store-and-forward off, the buffer is a plain cut-through FIFO: every stored beat is committed at once. Both mode pins are plain levels. `cfg_store_fwd` should be tied high for normal use. Both pins may change only while the block holds no frame and none is in progress.

The input stream never stalls in the middle of a frame in store-and-forward mode. It deasserts `in_ready` only at a frame boundary when storage is full, or in cut-through mode whenever storage is full. The output stream holds its beat stable until `out_ready` accepts it. The output has one register stage, so total capacity is DEPTH storage entries plus one output beat.

Top module: `pkt_sf_fifo`

## Requirements
- R1: After reset, `out_valid` is 0, `fill_level` is 0 and `in_ready` is 1.
- R2: In store-and-forward mode, no beat of a frame is presented before its end-of-packet beat is accepted. If the block was empty, `out_valid` is still 0 in the cycle right after that acceptance edge and becomes 1 one cycle later, showing the frame's first beat.
- R3: With store-and-forward and error discard both on, a frame whose end-of-packet beat has `in_err`=1 is discarded entirely. No beat of it is ever output, `fill_level` does not change, and the following frame is output normally.
- R4: With error discard off, an errored frame is forwarded whole. `out_err` reproduces the `in_err` value of each beat, so it is 1 only on the end beat when only that beat was flagged.
- R5: In store-and-forward mode, a frame that needs a storage slot while storage holds DEPTH uncommitted-or-committed beats is discarded. `in_ready` stays 1 for all its remaining beats, and earlier committed frames are output intact and in order.
- R6: `in_ready` is 0 only when storage is full. This happens at a frame boundary in store-and-forward mode, or at any time in cut-through mode. Whenever `in_ready` is 0, `fill_level` is at least DEPTH.
- R7: In cut-through mode, every accepted beat is committed at once. A beat accepted into an empty block raises `fill_level` to 1 in the next cycle and is on the output the cycle after.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data`, `out_sop`, `out_eop`, `out_empty` and `out_err` are held in the next cycle. Beats leave in the order they were committed.
- R9: `fill_level` equals the number of committed beats not yet accepted at the output, including the presented beat. It never exceeds DEPTH+1.
- R10: `out_sop`, `out_eop` and `out_empty` of each beat equal the values accepted with that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_store_fwd | input | 1 | 1: store-and-forward, 0: cut-through |
| cfg_drop_err | input | 1 | 1: discard frames whose end beat has the error flag (store-and-forward only) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 64 | Input beat data |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_empty | input | 3 | Unused byte count of the beat |
| in_err | input | 1 | Error flag of the beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat taken when high with out_valid |
| out_data | output | 64 | Output beat data |
| out_sop | output | 1 | First beat of a frame |
| out_eop | output | 1 | Last beat of a frame |
| out_empty | output | 3 | Unused byte count of the beat |
| out_err | output | 1 | Error flag of the beat |
| fill_level | output | 10 | Committed beats held, including the presented beat |

## Verification
The assertions check these properties on every cycle:
- the output beat is held during a stall;
- the fill bound holds;
- a deasserted `in_ready` comes only with full storage;
- a non-final beat never makes an empty store-and-forward buffer non-empty;
- an errored end beat leaves an empty buffer empty under discard;
- a cut-through beat reaches the output in two cycles.

Some behaviours only the bench's scenarios can show. These are the byte-exact content and order of drained frames, the sideband values per beat, the forwarded error flag, and the discard of an overflowing frame while an earlier frame survives intact. The bench uses a 16-entry buffer so that overflow and the full boundary are reached quickly.

// File: rtl/pkt_fifo_pkg.sv
`timescale 1ns/1ps
package pkt_fifo_pkg;
  // write-side frame tracking
  typedef enum logic [1:0] {
    WR_IDLE    = 2'd0,
    WR_FRAME   = 2'd1,
    WR_DISCARD = 2'd2
  } wr_state_e;
endpackage

// File: rtl/pkt_fifo_mem.sv
`timescale 1ns/1ps
module pkt_fifo_mem #(
  parameter int ENT_W  = 70,
  parameter int DEPTH  = 512,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ENT_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ENT_W-1:0]  rd_data
);
  logic [ENT_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // registered read port; holds its value while no read is issued
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/pkt_fifo_wr_ctrl.sv
`timescale 1ns/1ps
module pkt_fifo_wr_ctrl
  import pkt_fifo_pkg::*;
#(
  parameter int DEPTH  = 512,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_store_fwd,
  input  logic              cfg_drop_err,
  input  logic              in_valid,
  input  logic              in_eop,
  input  logic              in_err,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PTR_W-1:0]  commit_ptr
);
  wr_state_e        state;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] used;
  logic             mem_full;
  logic             accept;
  logic             overflow;
  logic             err_drop;

  assign used     = wr_ptr - rd_ptr;
  assign mem_full = (used == PTR_W'(DEPTH));
  // mid-frame in store-and-forward the input never stalls: overflow discards
  assign in_ready = !(mem_full && (state == WR_IDLE || !cfg_store_fwd));
  assign accept   = in_valid && in_ready;
  assign wr_en    = accept && (state != WR_DISCARD) && !mem_full;
  assign overflow = accept && cfg_store_fwd && (state == WR_FRAME) && mem_full;
  assign err_drop = wr_en && in_eop && in_err && cfg_drop_err && cfg_store_fwd;
  assign wr_addr  = wr_ptr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= WR_IDLE;
      wr_ptr     <= '0;
      commit_ptr <= '0;
    end else if (wr_en) begin
      if (err_drop) wr_ptr <= commit_ptr;
      else          wr_ptr <= wr_ptr + PTR_W'(1);
      if (!cfg_store_fwd || (in_eop && !err_drop))
        commit_ptr <= wr_ptr + PTR_W'(1);
      state <= in_eop ? WR_IDLE : WR_FRAME;
    end else if (overflow) begin
      wr_ptr <= commit_ptr;
      state  <= in_eop ? WR_IDLE : WR_DISCARD;
    end else if (accept && state == WR_DISCARD && in_eop) begin
      state <= WR_IDLE;
    end
  end
endmodule

// File: rtl/pkt_fifo_rd_ctrl.sv
`timescale 1ns/1ps
module pkt_fifo_rd_ctrl #(
  parameter int DEPTH  = 512,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1,
  localparam int LVL_W  = $clog2(DEPTH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  commit_ptr,
  input  logic              out_ready,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              out_valid,
  output logic [LVL_W-1:0]  fill_level
);
  logic [PTR_W-1:0] avail;

  assign avail      = commit_ptr - rd_ptr;
  assign rd_en      = (avail != '0) && (!out_valid || out_ready);
  assign rd_addr    = rd_ptr[ADDR_W-1:0];
  assign fill_level = LVL_W'(avail) + LVL_W'(out_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      out_valid <= 1'b0;
    end else begin
      if (rd_en) begin
        rd_ptr    <= rd_ptr + PTR_W'(1);
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pkt_sf_fifo.sv
`timescale 1ns/1ps
module pkt_sf_fifo #(
  parameter int DATA_W  = 64,
  parameter int EMPTY_W = 3,
  parameter int DEPTH   = 512,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1,
  localparam int LVL_W  = $clog2(DEPTH + 2),
  localparam int ENT_W  = DATA_W + EMPTY_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_store_fwd,
  input  logic               cfg_drop_err,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic [EMPTY_W-1:0] in_empty,
  input  logic               in_err,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_sop,
  output logic               out_eop,
  output logic [EMPTY_W-1:0] out_empty,
  output logic               out_err,
  output logic [LVL_W-1:0]   fill_level
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [PTR_W-1:0]  commit_ptr;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [PTR_W-1:0]  rd_ptr;
  logic [ENT_W-1:0]  wr_ent;
  logic [ENT_W-1:0]  rd_ent;

  // entry layout: {err, eop, sop, empty, data}
  assign wr_ent = {in_err, in_eop, in_sop, in_empty, in_data};
  assign out_data  = rd_ent[DATA_W-1:0];
  assign out_empty = rd_ent[DATA_W +: EMPTY_W];
  assign out_sop   = rd_ent[DATA_W+EMPTY_W];
  assign out_eop   = rd_ent[DATA_W+EMPTY_W+1];
  assign out_err   = rd_ent[DATA_W+EMPTY_W+2];

  pkt_fifo_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .cfg_store_fwd(cfg_store_fwd), .cfg_drop_err(cfg_drop_err),
    .in_valid(in_valid), .in_eop(in_eop), .in_err(in_err),
    .rd_ptr(rd_ptr), .in_ready(in_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .commit_ptr(commit_ptr)
  );

  pkt_fifo_mem #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_ent),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_ent)
  );

  pkt_fifo_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .commit_ptr(commit_ptr),
    .out_ready(out_ready), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_ptr(rd_ptr), .out_valid(out_valid), .fill_level(fill_level)
  );
endmodule

// File: rtl/pkt_sf_fifo_chk.sv
`timescale 1ns/1ps
module pkt_sf_fifo_chk #(
  parameter int DATA_W  = 64,
  parameter int EMPTY_W = 3,
  parameter int DEPTH   = 512,
  localparam int LVL_W  = $clog2(DEPTH + 2)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_store_fwd,
  input logic               cfg_drop_err,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_eop,
  input logic               in_err,
  input logic               out_valid,
  input logic               out_ready,
  input logic [DATA_W-1:0]  out_data,
  input logic               out_sop,
  input logic               out_eop,
  input logic [EMPTY_W-1:0] out_empty,
  input logic               out_err,
  input logic [LVL_W-1:0]   fill_level
);
  assert_out_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop)
      && $stable(out_eop) && $stable(out_empty) && $stable(out_err)));

  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LVL_W'(DEPTH + 1));

  assert_ready_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> fill_level >= LVL_W'(DEPTH));

  assert_sf_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_store_fwd && fill_level == '0 && in_valid && in_ready && !in_eop)
      |=> fill_level == '0);

  assert_err_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_store_fwd && cfg_drop_err && fill_level == '0 && in_valid && in_ready
      && in_eop && in_err) |=> (fill_level == '0 && !out_valid));

  assert_cut_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_store_fwd && in_valid && in_ready && fill_level == '0)
      |=> ##1 out_valid);
endmodule

bind pkt_sf_fifo pkt_sf_fifo_chk #(.DATA_W(DATA_W), .EMPTY_W(EMPTY_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_store_fwd(cfg_store_fwd), .cfg_drop_err(cfg_drop_err),
  .in_valid(in_valid), .in_ready(in_ready), .in_eop(in_eop), .in_err(in_err),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
  .out_eop(out_eop), .out_empty(out_empty), .out_err(out_err), .fill_level(fill_level)
);

// File: tb/pkt_sf_fifo_bench.sv
`timescale 1ns/1ps
module pkt_sf_fifo_bench;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_store_fwd = 1'b1, cfg_drop_err = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
  logic [63:0] in_data = '0;
  logic [2:0] in_empty = '0;
  logic in_ready, out_valid, out_sop, out_eop, out_err;
  logic out_ready = 1'b0;
  logic [63:0] out_data;
  logic [2:0] out_empty;
  logic [LVL_W-1:0] fill_level;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pkt_sf_fifo #(.DEPTH(DEPTH)) u_pkt_sf_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_store_fwd(cfg_store_fwd), .cfg_drop_err(cfg_drop_err),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop),
    .in_eop(in_eop), .in_empty(in_empty), .in_err(in_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_empty(out_empty), .out_err(out_err), .fill_level(fill_level)
  );

  function automatic logic [63:0] pat(int id, int b);
    return 64'h5A00_0000_0000_0000 ^ (64'(id) << 32) ^ 64'(b);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int id, input int b, input int n, input logic [2:0] emp, input logic err);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = pat(id, b);
    in_sop   = (b == 0);
    in_eop   = (b == n - 1);
    in_empty = (b == n - 1) ? emp : 3'd0;
    in_err   = (b == n - 1) ? err : 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = 1'b0; in_empty = '0;
  endtask

  task automatic get_beat(output logic [63:0] d, output logic s, output logic e,
                          output logic [2:0] em, output logic er);
    @(negedge clk);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    d = out_data; s = out_sop; e = out_eop; em = out_empty; er = out_err;
  endtask

  task automatic stop_out();
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  // drain n beats of frame id and compare every field
  task automatic expect_frame(input string tag, input int id, input int n,
                              input logic [2:0] emp, input logic err);
    logic [63:0] d; logic s, e, er; logic [2:0] em;
    for (int b = 0; b < n; b++) begin
      get_beat(d, s, e, em, er);
      check({tag, " data"}, d, pat(id, b));
      check({tag, " sop R10"}, 64'(s), 64'(b == 0));
      check({tag, " eop R10"}, 64'(e), 64'(b == n - 1));
      check({tag, " empty R10"}, 64'(em), 64'((b == n - 1) ? emp : 3'd0));
      check({tag, " err"}, 64'(er), 64'((b == n - 1) ? err : 1'b0));
    end
  endtask

  task automatic t_reset();
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 fill_level", 64'(fill_level), 64'd0);
    check("R1 in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_sf_hold();
    cfg_store_fwd = 1'b1; cfg_drop_err = 1'b0;
    for (int b = 0; b < 4; b++) put(1, b, 4, 3'd3, 1'b0);
    check("R2 fill before eop", 64'(fill_level), 64'd0);
    check("R2 no output before eop", 64'(out_valid), 64'd0);
    idle();
    check("R2 out_valid cycle after eop", 64'(out_valid), 64'd0);
    check("R9 fill after commit", 64'(fill_level), 64'd4);
    @(negedge clk);
    check("R2 out_valid two cycles after eop", 64'(out_valid), 64'd1);
    check("R9 fill with presented beat", 64'(fill_level), 64'd4);
    expect_frame("R2 frame1", 1, 4, 3'd3, 1'b0);
    stop_out();
    check("R9 fill after drain", 64'(fill_level), 64'd0);
  endtask

  task automatic t_drop_err();
    cfg_drop_err = 1'b1;
    for (int b = 0; b < 3; b++) put(2, b, 3, 3'd1, 1'b1);
    idle();
    check("R3 fill after errored frame", 64'(fill_level), 64'd0);
    @(negedge clk);
    check("R3 nothing output", 64'(out_valid), 64'd0);
    for (int b = 0; b < 2; b++) put(3, b, 2, 3'd5, 1'b0);
    idle();
    check("R3 fill after good frame", 64'(fill_level), 64'd2);
    expect_frame("R3 next frame", 3, 2, 3'd5, 1'b0);
    stop_out();
    cfg_drop_err = 1'b0;
  endtask

  task automatic t_fwd_err();
    for (int b = 0; b < 3; b++) put(4, b, 3, 3'd2, 1'b1);
    idle();
    check("R4 fill errored frame kept", 64'(fill_level), 64'd3);
    expect_frame("R4 forwarded", 4, 3, 3'd2, 1'b1);
    stop_out();
  endtask

  task automatic t_overflow();
    for (int b = 0; b < 12; b++) put(5, b, 12, 3'd0, 1'b0);
    idle();
    @(negedge clk);
    check("R5 fill frame A", 64'(fill_level), 64'd12);
    for (int b = 0; b < 8; b++) begin
      put(6, b, 8, 3'd0, 1'b0);
      check("R5 in_ready during dropped frame", 64'(in_ready), 64'd1);
    end
    idle();
    check("R5 fill after dropped frame", 64'(fill_level), 64'd12);
    for (int b = 0; b < 5; b++) begin
      put(7, b, 5, 3'd4, 1'b0);
      check("R6 in_ready while room", 64'(in_ready), 64'd1);
    end
    idle();
    check("R9 fill at capacity", 64'(fill_level), 64'(DEPTH + 1));
    check("R6 in_ready low when full", 64'(in_ready), 64'd0);
    expect_frame("R5 frame A", 5, 12, 3'd0, 1'b0);
    expect_frame("R5 frame C", 7, 5, 3'd4, 1'b0);
    stop_out();
    check("R6 in_ready after drain", 64'(in_ready), 64'd1);
    check("R9 fill empty", 64'(fill_level), 64'd0);
  endtask

  task automatic t_cut();
    cfg_store_fwd = 1'b0;
    put(8, 0, 2, 3'd6, 1'b0);
    idle();
    check("R7 fill one beat", 64'(fill_level), 64'd1);
    check("R7 not yet out", 64'(out_valid), 64'd0);
    @(negedge clk);
    check("R7 beat out before eop", 64'(out_valid), 64'd1);
    check("R7 data", out_data, pat(8, 0));
    put(8, 1, 2, 3'd6, 1'b0);
    idle();
    expect_frame("R7 frame", 8, 2, 3'd6, 1'b0);
    stop_out();
    cfg_store_fwd = 1'b1;
  endtask

  task automatic t_stall();
    logic [63:0] d; logic s, e, er; logic [2:0] em;
    logic [63:0] held;
    for (int b = 0; b < 6; b++) put(9, b, 6, 3'd7, 1'b0);
    idle();
    for (int b = 0; b < 6; b++) begin
      @(negedge clk);
      out_ready = 1'b0;
      @(negedge clk);
      held = out_data;
      @(negedge clk);
      check("R8 held during stall", out_data, held);
      check("R8 valid held", 64'(out_valid), 64'd1);
      get_beat(d, s, e, em, er);
      check("R8 order", d, pat(9, b));
      check("R10 eop", 64'(e), 64'(b == 5));
    end
    stop_out();
    check("R8 drained", 64'(fill_level), 64'd0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sf_hold();
    t_drop_err();
    t_fwd_err();
    t_overflow();
    t_cut();
    t_stall();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule